// File: doc/BRIEF.md
# UART Interrupt Status and Control

This block is the register-side interrupt logic of a fast serial port. The receiver and the transmitter report events as single-cycle pulses: receive trigger reached, receive timeout, framing error, line break detected and receive overrun. Each pulse is held in a sticky status bit until software clears it by writing a one to that bit. A transmit-request bit is raised when the transmit FIFO fill count drops to or below a programmable threshold. Software can also raise a separate transmit bit through its own set strobe.

Three enable bits in the control register select which groups of status bits drive the single interrupt line: transmit, receive and error. The error enable covers three sources at once. The same control register holds a forced-break bit that drives the transmit line low for as long as it is set, and a two-bit field that selects the transmit threshold. The FIFOs and the serializer sit outside this block. The block sees only the transmit fill count and the event pulses.

Top module: `hsu_irq_ctrl`

## Requirements
- R1: After reset the status vector, the control readback, the interrupt line and the break output are all zero.
- R2: Status bit positions are: 0 transmit request, 1 receive trigger, 2 receive timeout, 3 framing error, 4 break, 5 overrun, 6 software transmit set. An event pulse in cycle n sets its bit from cycle n+1, and the bit stays set until it is cleared.
- R3: A status write clears every bit whose write-data bit is 1 from the next cycle on, and leaves every bit whose write-data bit is 0 unchanged.
- R4: When an event and a clearing write hit the same status bit in the same cycle, the bit is set in the next cycle.
- R5: Control bits 1:0 select the transmit threshold: code 0 means 0 characters, code 1 means 4, code 2 means 8 and code 3 means 16. Status bit 0 sets only in the cycle after the fill count moves from above the threshold to at or below it. A level that stays at or below the threshold does not set the bit again, and no request is raised out of reset until such a crossing occurs.
- R6: A pulse on the software set strobe sets status bit 6. The bit is cleared in the same way as the other status bits.
- R7: The interrupt line is high exactly when some status bit is set and its group enable is set. Control bit 5 enables the transmit group (bits 0 and 6). Control bit 6 enables the receive group (bits 1 and 2).
- R8: Control bit 7 alone enables status bits 3, 4 and 5 together. With bit 7 clear, these three bits never raise the interrupt.
- R9: The break output equals control bit 8 from the cycle after the control write that sets or clears it.
- R10: A control write stores bits 1:0 and 8:5 of the write data. All other control bits read back as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stat_wr_i | input | 1 | Status write strobe (write-one-to-clear) |
| ctrl_wr_i | input | 1 | Control register write strobe |
| swset_i | input | 1 | Software transmit-interrupt set strobe |
| wdata_i | input | CTRL_W (9) | Register write data |
| ev_rx_trig_i | input | 1 | Receive trigger level reached pulse |
| ev_rx_tmo_i | input | 1 | Receive timeout pulse |
| ev_frame_i | input | 1 | Framing error pulse |
| ev_brk_i | input | 1 | Line break detected pulse |
| ev_ovr_i | input | 1 | Receive overrun pulse |
| tx_level_i | input | LVL_W (8) | Transmit FIFO fill count |
| status_o | output | 7 | Latched status bits |
| ctrl_o | output | CTRL_W (9) | Control register readback |
| irq_o | output | 1 | Interrupt request |
| brk_o | output | 1 | Forced break on the transmit line |

## Verification
Two things can land on the same status bit in one cycle: a hardware event setting it and a software write clearing it. The bench provokes this on purpose by pulsing an event in the same cycle as a status write with that bit's data set to one. It then expects the bit to read as set. A behavioural model follows every cycle under random stimulus and compares the outputs. In that random run, threshold crossings, threshold-code changes and clears also collide on bit 0.

// File: rtl/hsu_irq_pkg.sv
package hsu_irq_pkg;

   localparam int STAT_W    = 7;
   localparam int ST_TXREQ  = 0;
   localparam int ST_RXTRIG = 1;
   localparam int ST_RXTMO  = 2;
   localparam int ST_FRAME  = 3;
   localparam int ST_BRK    = 4;
   localparam int ST_OVR    = 5;
   localparam int ST_SWSET  = 6;

   localparam int CT_THR_LO = 0;
   localparam int CT_THR_HI = 1;
   localparam int CT_TXEN   = 5;
   localparam int CT_RXEN   = 6;
   localparam int CT_ERREN  = 7;
   localparam int CT_BRK    = 8;
   localparam int CTRL_MIN_W = CT_BRK + 1;

   typedef enum logic [1:0] {
      GRP_TX  = 2'd0,
      GRP_RX  = 2'd1,
      GRP_ERR = 2'd2
   } irq_grp_e;

   function automatic int grp_of(input int bit_idx);
      case (bit_idx)
         ST_TXREQ, ST_SWSET:   return int'(GRP_TX);
         ST_RXTRIG, ST_RXTMO:  return int'(GRP_RX);
         default:              return int'(GRP_ERR);
      endcase
   endfunction

   function automatic int thr_chars(input logic [1:0] code);
      case (code)
         2'd0:    return 0;
         2'd1:    return 4;
         2'd2:    return 8;
         default: return 16;
      endcase
   endfunction

   function automatic logic [CTRL_MIN_W-1:0] ctrl_keep_mask();
      logic [CTRL_MIN_W-1:0] m;
      m = '0;
      m[CT_THR_LO] = 1'b1;
      m[CT_THR_HI] = 1'b1;
      m[CT_TXEN]   = 1'b1;
      m[CT_RXEN]   = 1'b1;
      m[CT_ERREN]  = 1'b1;
      m[CT_BRK]    = 1'b1;
      return m;
   endfunction

endpackage

// File: rtl/hsu_irq_ctrlreg.sv
module hsu_irq_ctrlreg
   import hsu_irq_pkg::*;
#(
   parameter int CTRL_W = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic [CTRL_W-1:0] wdata_i,
   output logic [CTRL_W-1:0] ctrl_o,
   output logic [1:0]        thr_code_o,
   output logic [2:0]        grp_en_o,
   output logic              brk_o
);

   localparam logic [CTRL_W-1:0] KEEP = CTRL_W'(ctrl_keep_mask());

   logic [CTRL_W-1:0] ctrl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    ctrl_q <= '0;
      else if (wr_i) ctrl_q <= wdata_i & KEEP;
   end

   assign ctrl_o     = ctrl_q;
   assign thr_code_o = ctrl_q[CT_THR_HI:CT_THR_LO];
   assign grp_en_o[int'(GRP_TX)]  = ctrl_q[CT_TXEN];
   assign grp_en_o[int'(GRP_RX)]  = ctrl_q[CT_RXEN];
   assign grp_en_o[int'(GRP_ERR)] = ctrl_q[CT_ERREN];
   assign brk_o      = ctrl_q[CT_BRK];

   // R9: break output follows the written break bit
   assert_break_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
      wr_i |=> (brk_o == $past(wdata_i[CT_BRK])));

   // R10: a cycle without a write keeps the control value
   assert_ctrl_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_i |=> $stable(ctrl_o));

endmodule

// File: rtl/hsu_irq_txreq.sv
module hsu_irq_txreq
   import hsu_irq_pkg::*;
#(
   parameter int LVL_W      = 8,
   parameter int FIFO_DEPTH = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LVL_W-1:0] level_i,
   input  logic [1:0]       thr_code_i,
   output logic             tx_ev_o
);

   localparam int CW = LVL_W + 1;

   if (FIFO_DEPTH <= 16) begin : g_chk_depth
      $error("FIFO_DEPTH must exceed the largest threshold");
   end
   if ((1 << LVL_W) <= FIFO_DEPTH) begin : g_chk_lvl
      $error("LVL_W too narrow for FIFO_DEPTH");
   end

   logic [CW-1:0] thr_w;
   logic          below;
   logic          below_q;

   assign thr_w = CW'(thr_chars(thr_code_i));
   assign below = ({1'b0, level_i} <= thr_w);

   // reset to 'below' so that an empty FIFO after reset raises no request
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) below_q <= 1'b1;
      else        below_q <= below;
   end

   assign tx_ev_o = below & ~below_q;

   // R5: a crossing is an edge and cannot repeat in the next cycle
   assert_txreq_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
      tx_ev_o |=> !tx_ev_o);

endmodule

// File: rtl/hsu_irq_status.sv
module hsu_irq_status
   import hsu_irq_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [STAT_W-1:0] ev_i,
   input  logic              clr_we_i,
   input  logic [STAT_W-1:0] clr_i,
   output logic [STAT_W-1:0] stat_o
);

   for (genvar gi = 0; gi < STAT_W; gi++) begin : g_bit
      logic bit_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                        bit_q <= 1'b0;
         else if (ev_i[gi])                 bit_q <= 1'b1;
         else if (clr_we_i && clr_i[gi])    bit_q <= 1'b0;
      end

      assign stat_o[gi] = bit_q;

      // R4: event beats a same-cycle clear
      assert_event_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
         ev_i[gi] |=> stat_o[gi]);

      // R3: a clear without an event empties the bit
      assert_w1c_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_we_i && clr_i[gi] && !ev_i[gi]) |=> !stat_o[gi]);

      // R2: sticky when neither event nor clear
      assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
         (!ev_i[gi] && !(clr_we_i && clr_i[gi])) |=> $stable(stat_o[gi]));
   end

endmodule

// File: rtl/hsu_irq_ctrl.sv
module hsu_irq_ctrl
   import hsu_irq_pkg::*;
#(
   parameter int CTRL_W     = 9,
   parameter int LVL_W      = 8,
   parameter int FIFO_DEPTH = 64,
   parameter bit IRQ_REG    = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stat_wr_i,
   input  logic              ctrl_wr_i,
   input  logic              swset_i,
   input  logic [CTRL_W-1:0] wdata_i,
   input  logic              ev_rx_trig_i,
   input  logic              ev_rx_tmo_i,
   input  logic              ev_frame_i,
   input  logic              ev_brk_i,
   input  logic              ev_ovr_i,
   input  logic [LVL_W-1:0]  tx_level_i,
   output logic [STAT_W-1:0] status_o,
   output logic [CTRL_W-1:0] ctrl_o,
   output logic              irq_o,
   output logic              brk_o
);

   if (CTRL_W < CTRL_MIN_W) begin : g_chk_ctrl
      $error("CTRL_W too narrow for the control fields");
   end

   logic [1:0]        thr_code;
   logic [2:0]        grp_en;
   logic              tx_ev;
   logic [STAT_W-1:0] ev_vec;
   logic [STAT_W-1:0] masked;
   logic              irq_c;

   hsu_irq_ctrlreg #(.CTRL_W(CTRL_W)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_i       (ctrl_wr_i),
      .wdata_i    (wdata_i),
      .ctrl_o     (ctrl_o),
      .thr_code_o (thr_code),
      .grp_en_o   (grp_en),
      .brk_o      (brk_o)
   );

   hsu_irq_txreq #(.LVL_W(LVL_W), .FIFO_DEPTH(FIFO_DEPTH)) u_txreq (
      .clk        (clk),
      .rst_n      (rst_n),
      .level_i    (tx_level_i),
      .thr_code_i (thr_code),
      .tx_ev_o    (tx_ev)
   );

   always_comb begin
      ev_vec            = '0;
      ev_vec[ST_TXREQ]  = tx_ev;
      ev_vec[ST_RXTRIG] = ev_rx_trig_i;
      ev_vec[ST_RXTMO]  = ev_rx_tmo_i;
      ev_vec[ST_FRAME]  = ev_frame_i;
      ev_vec[ST_BRK]    = ev_brk_i;
      ev_vec[ST_OVR]    = ev_ovr_i;
      ev_vec[ST_SWSET]  = swset_i;
   end

   hsu_irq_status u_stat (
      .clk      (clk),
      .rst_n    (rst_n),
      .ev_i     (ev_vec),
      .clr_we_i (stat_wr_i),
      .clr_i    (wdata_i[STAT_W-1:0]),
      .stat_o   (status_o)
   );

   for (genvar gi = 0; gi < STAT_W; gi++) begin : g_mask
      localparam int GRP = grp_of(gi);
      assign masked[gi] = status_o[gi] & grp_en[GRP];
   end

   assign irq_c = |masked;

   if (IRQ_REG) begin : g_irq_reg
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= irq_c;
      end
      assign irq_o = irq_q;
   end else begin : g_irq_comb
      assign irq_o = irq_c;
   end

   // R8: with the error enable clear, error bits alone cannot raise the line
   assert_err_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_o[CT_ERREN] && !ctrl_o[CT_TXEN] && !ctrl_o[CT_RXEN]) |-> !irq_c);

endmodule

// File: tb/hsu_irq_ctrl_tb.sv
module hsu_irq_ctrl_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       stat_wr = 0, ctrl_wr = 0, swset = 0;
   logic [8:0] wdata = '0;
   logic       e_trig = 0, e_tmo = 0, e_fe = 0, e_brk = 0, e_ovr = 0;
   logic [7:0] lvl = 8'd0;
   logic [6:0] status;
   logic [8:0] ctrl;
   logic       irq, brk;

   int n_chk = 0;
   int n_fail = 0;
   int cycles = 0;

   always #10 clk = ~clk;

   hsu_irq_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .stat_wr_i(stat_wr), .ctrl_wr_i(ctrl_wr),
      .swset_i(swset), .wdata_i(wdata), .ev_rx_trig_i(e_trig),
      .ev_rx_tmo_i(e_tmo), .ev_frame_i(e_fe), .ev_brk_i(e_brk),
      .ev_ovr_i(e_ovr), .tx_level_i(lvl), .status_o(status),
      .ctrl_o(ctrl), .irq_o(irq), .brk_o(brk)
   );

   // ---------------- behavioural reference model ----------------
   int m_stat, m_ctrl;
   bit m_below_q;

   function automatic int thr_of(int code);
      if (code == 0) return 0;
      if (code == 1) return 4;
      if (code == 2) return 8;
      return 16;
   endfunction

   function automatic bit m_irq();
      bit te, re, ee;
      te = m_ctrl[5]; re = m_ctrl[6]; ee = m_ctrl[7];
      return (te && (m_stat[0] || m_stat[6])) ||
             (re && (m_stat[1] || m_stat[2])) ||
             (ee && (m_stat[3] || m_stat[4] || m_stat[5]));
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_stat = 0; m_ctrl = 0; m_below_q = 1'b1;
      end else begin
         int ev, clr;
         bit below;
         below = (int'(lvl) <= thr_of(m_ctrl & 3));
         ev = 0;
         if (below && !m_below_q) ev |= 1;
         if (e_trig) ev |= 2;
         if (e_tmo)  ev |= 4;
         if (e_fe)   ev |= 8;
         if (e_brk)  ev |= 16;
         if (e_ovr)  ev |= 32;
         if (swset)  ev |= 64;
         clr = stat_wr ? int'(wdata[6:0]) : 0;
         m_stat = (m_stat & ~clr) | ev;
         m_below_q = below;
         if (ctrl_wr) m_ctrl = int'(wdata) & 'h1E3;
      end
   end

   task automatic chk(bit ok, string tag, string what, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   bit cmp_on = 0;
   always @(negedge clk) begin
      if (cmp_on && rst_n) begin
         chk(int'(status) == m_stat, "R2", "model status", int'(status), m_stat);
         chk(irq == m_irq(), "R7", "model irq", int'(irq), int'(m_irq()));
         chk(brk == m_ctrl[8], "R9", "model brk", int'(brk), m_ctrl[8]);
         chk(int'(ctrl) == m_ctrl, "R10", "model ctrl", int'(ctrl), m_ctrl);
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic idle();
      stat_wr = 0; ctrl_wr = 0; swset = 0;
      e_trig = 0; e_tmo = 0; e_fe = 0; e_brk = 0; e_ovr = 0;
   endtask

   task automatic step();
      @(negedge clk);
      idle();
   endtask

   task automatic clr_stat(logic [6:0] m);
      @(negedge clk); idle(); stat_wr = 1; wdata = {2'b0, m};
      step();
   endtask

   task automatic wr_ctrl(logic [8:0] v);
      @(negedge clk); idle(); ctrl_wr = 1; wdata = v;
      step();
   endtask

   // ---------------- watchdog ----------------
   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=%0d expected<100000", cycles);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk(status == 0, "R1", "status", int'(status), 0);
      chk(ctrl == 0, "R1", "ctrl", int'(ctrl), 0);
      chk(irq == 0 && brk == 0, "R1", "irq/brk", {irq, brk}, 0);
      cmp_on = 1;

      // R2 each event sets its own bit
      for (int b = 1; b <= 5; b++) begin
         @(negedge clk); idle();
         case (b)
            1: e_trig = 1; 2: e_tmo = 1; 3: e_fe = 1; 4: e_brk = 1; default: e_ovr = 1;
         endcase
         step();
         chk(status[b] == 1, "R2", "event bit", int'(status), 1 << b);
         step();
         chk(status[b] == 1, "R2", "sticky bit", int'(status), 1 << b);
      end
      // R3 write zero leaves bits, write one clears
      clr_stat(7'h00);
      chk(status == 7'h3E, "R3", "write zero", int'(status), 'h3E);
      clr_stat(7'h0A);
      chk(status == 7'h34, "R3", "partial clear", int'(status), 'h34);
      clr_stat(7'h7F);
      chk(status == 0, "R3", "full clear", int'(status), 0);

      // R4 collision
      @(negedge clk); idle(); stat_wr = 1; wdata = 9'h008; e_fe = 1;
      step();
      chk(status[3] == 1, "R4", "event vs clear", int'(status), 'h08);
      clr_stat(7'h7F);

      // R6 software set
      @(negedge clk); idle(); swset = 1;
      step();
      chk(status == 7'h40, "R6", "sw set", int'(status), 'h40);
      clr_stat(7'h40);
      chk(status == 0, "R6", "sw clear", int'(status), 0);

      // R5 thresholds
      for (int c = 0; c < 4; c++) begin
         int t;
         t = thr_of(c);
         wr_ctrl(9'(c));
         @(negedge clk); lvl = 8'd40;
         step(); step();
         clr_stat(7'h01);
         @(negedge clk); lvl = 8'(t + 1);
         step();
         chk(status[0] == 0, "R5", "above threshold", int'(status[0]), 0);
         @(negedge clk); lvl = 8'(t);
         step();
         chk(status[0] == 1, "R5", "crossing", int'(status[0]), 1);
         clr_stat(7'h01);
         step();
         chk(status[0] == 0, "R5", "no re-raise", int'(status[0]), 0);
      end

      // R7 / R8 enable gating
      clr_stat(7'h7F);
      @(negedge clk); idle(); e_fe = 1; e_ovr = 1;
      step();
      chk(irq == 0, "R8", "error gated off", int'(irq), 0);
      wr_ctrl(9'h080);
      chk(irq == 1, "R8", "error enabled", int'(irq), 1);
      wr_ctrl(9'h060);
      chk(irq == 0, "R8", "tx/rx enable only", int'(irq), 0);
      @(negedge clk); idle(); e_tmo = 1;
      step();
      chk(irq == 1, "R7", "rx group", int'(irq), 1);
      wr_ctrl(9'h020);
      chk(irq == 0, "R7", "rx disabled", int'(irq), 0);
      @(negedge clk); idle(); swset = 1;
      step();
      chk(irq == 1, "R7", "tx group swset", int'(irq), 1);
      clr_stat(7'h7F);

      // R9 / R10 break and readback
      wr_ctrl(9'h1FF);
      chk(brk == 1, "R9", "break on", int'(brk), 1);
      chk(ctrl == 9'h1E3, "R10", "readback mask", int'(ctrl), 'h1E3);
      wr_ctrl(9'h0E3);
      chk(brk == 0, "R9", "break off", int'(brk), 0);

      // random traffic against the model
      for (int i = 0; i < 3000; i++) begin
         @(negedge clk);
         idle();
         stat_wr = ($urandom_range(0, 5) == 0);
         ctrl_wr = ($urandom_range(0, 15) == 0);
         wdata   = 9'($urandom);
         swset   = ($urandom_range(0, 20) == 0);
         e_trig  = ($urandom_range(0, 9) == 0);
         e_tmo   = ($urandom_range(0, 9) == 0);
         e_fe    = ($urandom_range(0, 9) == 0);
         e_brk   = ($urandom_range(0, 9) == 0);
         e_ovr   = ($urandom_range(0, 9) == 0);
         lvl     = 8'($urandom_range(0, 24));
      end
      step();
      step();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule